// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus that a slave device is holding. A typical cause is a slave that lost a clock edge part way through a byte and is still waiting to drive an acknowledge. A one-cycle request starts a recovery run. The block drives SCL and SDA only through open-drain low-enable outputs and watches the real line levels on two inputs. When the run finishes it raises a one-cycle done pulse, along with an error flag and a flag that says whether SDA was found stuck.

The run has two modes. In the framed-pulse mode the block emits nine SCL pulses. Each pulse has a start condition before it and a stop condition after it, and the stops are spaced by twice a base delay that is derived from the bus rate. In the probing mode the block first samples SDA before driving anything, then issues a start and waits for the bus to look busy. If SDA was low before the start, the block releases both lines, issues a second start, clocks one receive byte and ends with a stop. If SDA was free, it clocks the receive byte and ends with a stop directly. Every wait for the bus has a timeout, and a timeout aborts the run with an error.

Top module: `i2c_unstick_top`

## Requirements
- R1: After reset, and whenever the block is idle, `scl_low_o`, `sda_low_o`, `busy_o` and `done_o` are 0. The block never drives a line high: a 0 on a low-enable output releases the line.
- R2: A run starts only when `req_i` is high while the block is idle. A request that arrives during a run is ignored: the run is not restarted or extended, and exactly one done pulse follows.
- R3: With `mode_i`=0 the block makes exactly 9 SCL low pulses. Before each pulse it asserts SDA low while SCL is released (a start), and it releases SDA only after SCL has been released again (a stop). This gives 9 SDA assertions per run.
- R4: The base delay is max(2, 1000/BUS_KHZ+1) microseconds, or that value times CLK_MHZ clock cycles. Every SCL low phase lasts at least one base delay. In mode 0, both lines stay released for at least two base delays after each stop.
- R5: With `mode_i`=1 the block samples SDA before it drives anything. SDA low at that point sets `sda_stuck_o`=1, and SDA high sets it to 0. In mode 0, `sda_stuck_o` is 0.
- R6: Mode 1 with SDA stuck runs: start, release of both lines, a second start, a 9-clock receive byte with SDA released, then a stop. That is 3 SDA assertions and 10 SCL low pulses in total.
- R7: Mode 1 with SDA free runs: start, a 9-clock receive byte, then a stop. That is 2 SDA assertions and 10 SCL low pulses.
- R8: In mode 1 the wait for bus busy (SCL high while SDA is low) lasts at most TMO_US*CLK_MHZ cycles. If SCL is held low, the run ends with `err_o`=1 no sooner than that many cycles after the request.
- R9: After each SCL release the block waits until SCL reads high, so a slave that stretches the clock for a short time causes no error. If SCL stays low for longer than the timeout window, the run ends with `err_o`=1 and no further pulses.
- R10: `done_o` is a one-cycle pulse, and `busy_o` falls in the cycle after it. `err_o` and `sda_stuck_o` are valid with `done_o` and hold their values until the next accepted request, which clears them. Both lines are released when the run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Recovery request pulse |
| mode_i | input | 1 | 0: nine framed pulses, 1: probe SDA and take one of two finishing paths |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_low_o | output | 1 | SCL pull-down enable |
| sda_low_o | output | 1 | SDA pull-down enable |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Last run ended on a timeout |
| sda_stuck_o | output | 1 | Last probe found SDA low |

## Verification
The embedded properties check, on every cycle, that:
- both lines are released while the block is idle;
- a run can only begin from a request;
- the done pulse ends the run;
- the result flags stay frozen between runs;
- each SCL low phase lasts at least one base delay;
- a clock-stretch timeout fires only after a full window.

Some behaviour depends on what a modelled slave does on the wire, and only the directed scenarios can show it:
- the pulse and SDA-assertion counts that tell the three paths apart;
- the spacing between stops;
- tolerance of a short stretch;
- the latency of the busy-wait timeout;
- the handling of a request that arrives during a run.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FR_START,
    S_FR_CLK,
    S_FR_STOP,
    S_PROBE,
    S_SEIZE,
    S_RELEASE,
    S_BYTE,
    S_END_LOW,
    S_END_HIGH,
    S_DONE
  } top_state_e;

  typedef enum logic [1:0] {
    C_IDLE,
    C_LOW,
    C_RISE,
    C_HIGH
  } clk_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/i2c_unstick_tmr.sv
module i2c_unstick_tmr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_unstick_clk.sv
module i2c_unstick_clk
  import i2c_unstick_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int BASE_CYC = 30,
  parameter int TMO_CYC  = 1000,
  parameter int NP_W     = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NP_W-1:0] npulse_i,
  input  logic            scl_i,
  output logic            scl_low_o,
  output logic            done_o,
  output logic            tmo_o
);
  localparam logic [CNT_W-1:0] BASE_V = CNT_W'(BASE_CYC);
  localparam logic [CNT_W-1:0] TMO_V  = CNT_W'(TMO_CYC);

  clk_state_e      st_q, st_d;
  logic [NP_W-1:0] left_q;
  logic            t_load, t_zero;
  logic [CNT_W-1:0] t_val;

  i2c_unstick_tmr #(.W(CNT_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(t_load),
    .val_i (t_val),
    .zero_o(t_zero)
  );

  always_comb begin
    st_d   = st_q;
    t_load = 1'b0;
    t_val  = BASE_V;
    unique case (st_q)
      C_IDLE: if (start_i) begin
        st_d = C_LOW; t_load = 1'b1;
      end
      C_LOW: if (t_zero) begin
        st_d = C_RISE; t_load = 1'b1; t_val = TMO_V;
      end
      C_RISE: begin
        if (scl_i) begin
          st_d = C_HIGH; t_load = 1'b1;
        end else if (t_zero) begin
          st_d = C_IDLE;
        end
      end
      C_HIGH: if (t_zero) begin
        if (left_q == NP_W'(1)) st_d = C_IDLE;
        else begin
          st_d = C_LOW; t_load = 1'b1;
        end
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= C_IDLE;
      left_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == C_IDLE && start_i)   left_q <= npulse_i;
      else if (st_q == C_HIGH && t_zero) left_q <= left_q - 1'b1;
    end
  end

  assign scl_low_o = (st_q == C_LOW);
  assign tmo_o     = (st_q == C_RISE) && !scl_i && t_zero;
  assign done_o    = tmo_o || ((st_q == C_HIGH) && t_zero && (left_q == NP_W'(1)));

  // checker counters
  logic [CNT_W-1:0] low_run_q, wait_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run_q  <= '0;
      wait_run_q <= '0;
    end else begin
      low_run_q  <= scl_low_o ? low_run_q + 1'b1 : '0;
      wait_run_q <= (st_q == C_RISE) ? wait_run_q + 1'b1 : '0;
    end
  end

  // R4
  low_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_low_o) |-> (low_run_q >= BASE_V));

  // R9
  stretch_tmo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> (wait_run_q >= TMO_V));
endmodule

// File: rtl/i2c_unstick_top.sv
module i2c_unstick_top
  import i2c_unstick_pkg::*;
#(
  parameter int CLK_MHZ    = 100,
  parameter int BUS_KHZ    = 100,
  parameter int TMO_US     = 100,
  parameter int NUM_FRAMES = 9,
  parameter int BYTE_CLKS  = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic mode_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_low_o,
  output logic sda_low_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o,
  output logic sda_stuck_o
);
  localparam int BASE_US  = max2(2, 1000 / BUS_KHZ + 1);
  localparam int BASE_CYC = BASE_US * CLK_MHZ;
  localparam int TMO_CYC  = TMO_US * CLK_MHZ;
  localparam int CNT_W    = $clog2(max2(TMO_CYC, 2 * BASE_CYC) + 1);
  localparam int NP_W     = $clog2(max2(NUM_FRAMES, BYTE_CLKS) + 1);
  localparam logic [CNT_W-1:0] BASE_V = CNT_W'(BASE_CYC);
  localparam logic [CNT_W-1:0] GAP_V  = CNT_W'(2 * BASE_CYC);
  localparam logic [CNT_W-1:0] TMO_V  = CNT_W'(TMO_CYC);

  top_state_e       st_q, st_d;
  logic [NP_W-1:0]  frames_q;
  logic             stuck_q, err_q, second_q, hold_q;
  logic             t_load, t_zero;
  logic [CNT_W-1:0] t_val;
  logic             c_start, c_scl_low, c_done, c_tmo;
  logic [NP_W-1:0]  c_n;
  logic             bus_busy;

  assign bus_busy = scl_i && !sda_i;

  i2c_unstick_tmr #(.W(CNT_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(t_load),
    .val_i (t_val),
    .zero_o(t_zero)
  );

  i2c_unstick_clk #(
    .CNT_W   (CNT_W),
    .BASE_CYC(BASE_CYC),
    .TMO_CYC (TMO_CYC),
    .NP_W    (NP_W)
  ) u_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (c_start),
    .npulse_i (c_n),
    .scl_i    (scl_i),
    .scl_low_o(c_scl_low),
    .done_o   (c_done),
    .tmo_o    (c_tmo)
  );

  always_comb begin
    st_d    = st_q;
    t_load  = 1'b0;
    t_val   = BASE_V;
    c_start = 1'b0;
    c_n     = NP_W'(1);
    unique case (st_q)
      S_IDLE: if (req_i) begin
        if (mode_i) st_d = S_PROBE;
        else begin
          st_d = S_FR_START; t_load = 1'b1;
        end
      end
      S_FR_START: if (t_zero) begin
        st_d = S_FR_CLK; c_start = 1'b1;
      end
      S_FR_CLK: if (c_done) begin
        if (c_tmo) st_d = S_DONE;
        else begin
          st_d = S_FR_STOP; t_load = 1'b1; t_val = GAP_V;
        end
      end
      S_FR_STOP: if (t_zero) begin
        if (frames_q == NP_W'(NUM_FRAMES - 1)) st_d = S_DONE;
        else begin
          st_d = S_FR_START; t_load = 1'b1;
        end
      end
      S_PROBE: begin
        st_d = S_SEIZE; t_load = 1'b1; t_val = TMO_V;
      end
      S_SEIZE: begin
        if (bus_busy) begin
          if (stuck_q && !second_q) begin
            st_d = S_RELEASE; t_load = 1'b1;
          end else begin
            st_d = S_BYTE; c_start = 1'b1; c_n = NP_W'(BYTE_CLKS);
          end
        end else if (t_zero) begin
          st_d = S_DONE;
        end
      end
      S_RELEASE: if (t_zero) begin
        st_d = S_SEIZE; t_load = 1'b1; t_val = TMO_V;
      end
      S_BYTE: if (c_done) begin
        if (c_tmo) st_d = S_DONE;
        else begin
          st_d = S_END_LOW; t_load = 1'b1;
        end
      end
      S_END_LOW: if (t_zero) begin
        st_d = S_END_HIGH; t_load = 1'b1;
      end
      S_END_HIGH: if (t_zero) st_d = S_DONE;
      S_DONE:     st_d = S_IDLE;
      default:    st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      frames_q <= '0;
      stuck_q  <= 1'b0;
      err_q    <= 1'b0;
      second_q <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      unique case (st_q)
        S_IDLE: if (req_i) begin
          frames_q <= '0;
          stuck_q  <= 1'b0;
          err_q    <= 1'b0;
          second_q <= 1'b0;
        end
        S_FR_CLK:  if (c_tmo) err_q <= 1'b1;
        S_FR_STOP: if (t_zero) frames_q <= frames_q + 1'b1;
        S_PROBE:   stuck_q <= !sda_i;
        S_SEIZE: begin
          if (bus_busy && !(stuck_q && !second_q)) hold_q <= 1'b1;
          else if (!bus_busy && t_zero)           err_q  <= 1'b1;
        end
        S_RELEASE: if (t_zero) second_q <= 1'b1;
        S_BYTE: begin
          if (c_scl_low) hold_q <= 1'b0;
          if (c_tmo)     err_q  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    scl_low_o = 1'b0;
    sda_low_o = 1'b0;
    unique case (st_q)
      S_FR_START, S_SEIZE, S_END_HIGH: sda_low_o = 1'b1;
      S_FR_CLK: begin
        scl_low_o = c_scl_low; sda_low_o = 1'b1;
      end
      S_BYTE: begin
        scl_low_o = c_scl_low; sda_low_o = hold_q;
      end
      S_END_LOW: begin
        scl_low_o = 1'b1; sda_low_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = (st_q == S_DONE);
  assign err_o       = err_q;
  assign sda_stuck_o = stuck_q;

  // R1
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_low_o && !sda_low_o));

  // R2
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i));

  // R10
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  // R10
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> ($stable(err_o) && $stable(sda_stuck_o)));
endmodule

// File: tb/i2c_unstick_top_tb_top.sv
module i2c_unstick_top_tb_top;
  localparam int CLK_MHZ = 10;
  localparam int BUS_KHZ = 400;
  localparam int TMO_US  = 100;
  localparam int BASE    = 30;   // max(2,1000/400+1)=3 us * 10
  localparam int TMO     = 1000; // 100 us * 10

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, mode = 1'b0;
  logic sl_scl = 1'b0, sl_sda = 1'b0;
  logic scl_low, sda_low, busy, done, err, stuck;
  wire  scl_line = !(scl_low || sl_scl);
  wire  sda_line = !(sda_low || sl_sda);

  int checks = 0, errors = 0;
  int scl_rises, sda_rises, dones, min_low, min_gap, lrun, grun;
  int stuck_release_after = 0, scl_line_rises;
  logic p_scl = 1'b0, p_sda = 1'b0, p_line = 1'b1;

  always #50 clk = ~clk;

  i2c_unstick_top #(
    .CLK_MHZ(CLK_MHZ), .BUS_KHZ(BUS_KHZ), .TMO_US(TMO_US),
    .NUM_FRAMES(9), .BYTE_CLKS(9)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mode_i(mode),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_low_o(scl_low), .sda_low_o(sda_low), .busy_o(busy),
    .done_o(done), .err_o(err), .sda_stuck_o(stuck)
  );

  always @(negedge clk) begin
    if (scl_low && !p_scl) scl_rises++;
    if (sda_low && !p_sda) sda_rises++;
    if (done) dones++;
    if (scl_low) lrun++;
    else begin
      if (p_scl && lrun < min_low) min_low = lrun;
      lrun = 0;
    end
    if (busy && !scl_low && !sda_low) grun++;
    else begin
      if (grun > 0 && (scl_low || sda_low) && grun < min_gap) min_gap = grun;
      grun = 0;
    end
    if (scl_line && !p_line) scl_line_rises++;
    if (stuck_release_after > 0 && scl_line_rises >= stuck_release_after) begin
      sl_sda = 1'b0;
      stuck_release_after = 0;
    end
    p_scl  = scl_low;
    p_sda  = sda_low;
    p_line = scl_line;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    scl_rises = 0; sda_rises = 0; dones = 0;
    min_low = 1 << 30; min_gap = 1 << 30; lrun = 0; grun = 0;
    scl_line_rises = 0;
  endtask

  task automatic pulse_req(input logic m);
    @(negedge clk);
    mode = m; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_done(input int limit, output int cyc);
    cyc = 0;
    while (!done && cyc < limit) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    chk(!scl_low && !sda_low, "R1 lines released in reset", int'(scl_low | sda_low), 0);
    chk(!busy && !done, "R1 idle in reset", int'(busy | done), 0);
  endtask

  task automatic t_std();
    int cyc;
    clr_mon();
    pulse_req(1'b0);
    repeat (100) @(negedge clk);
    req = 1'b1; @(negedge clk); req = 1'b0;   // ignored mid-run
    wait_done(20000, cyc);
    repeat (3) @(negedge clk);
    chk(dones == 1, "R2 one done per accepted request", dones, 1);
    chk(scl_rises == 9, "R3 scl pulses", scl_rises, 9);
    chk(sda_rises == 9, "R3 framing starts", sda_rises, 9);
    chk(min_low >= BASE, "R4 scl low width", min_low, BASE);
    chk(min_gap >= 2 * BASE, "R4 stop spacing", min_gap, 2 * BASE);
    chk(!err && !stuck, "R5 mode0 flags clear", int'({err, stuck}), 0);
    chk(!busy && !scl_low && !sda_low, "R10 released after run", int'({busy, scl_low, sda_low}), 0);
  endtask

  task automatic t_stretch(input int hold, input bit expect_err, input int exp_pulses);
    int cyc;
    clr_mon();
    pulse_req(1'b0);
    while (!scl_low) @(negedge clk);
    sl_scl = 1'b1;
    repeat (hold) @(negedge clk);
    sl_scl = 1'b0;
    wait_done(20000, cyc);
    chk(err == expect_err, "R9 stretch error flag", int'(err), int'(expect_err));
    @(negedge clk);
    chk(scl_rises == exp_pulses, "R9 pulses after stretch", scl_rises, exp_pulses);
  endtask

  task automatic t_hold_err();
    repeat (20) @(negedge clk);
    chk(err == 1'b1, "R10 err held while idle", int'(err), 1);
  endtask

  task automatic t_alt(input bit stick);
    int cyc;
    clr_mon();
    if (stick) begin
      sl_sda = 1'b1;
      stuck_release_after = 3;
    end
    pulse_req(1'b1);
    repeat (3) @(negedge clk);
    chk(err == 1'b0, "R10 err cleared on accept", int'(err), 0);
    wait_done(20000, cyc);
    chk(stuck == stick, "R5 stuck flag", int'(stuck), int'(stick));
    chk(err == 1'b0, stick ? "R6 no error" : "R7 no error", int'(err), 0);
    @(negedge clk);
    chk(sda_rises == (stick ? 3 : 2), stick ? "R6 sda assertions" : "R7 sda assertions",
        sda_rises, stick ? 3 : 2);
    chk(scl_rises == 10, stick ? "R6 scl pulses" : "R7 scl pulses", scl_rises, 10);
    chk(!scl_low && !sda_low, "R10 released", int'({scl_low, sda_low}), 0);
  endtask

  task automatic t_busy_tmo();
    int cyc;
    clr_mon();
    sl_scl = 1'b1;
    pulse_req(1'b1);
    wait_done(5000, cyc);
    chk(err == 1'b1, "R8 busy wait error", int'(err), 1);
    chk(cyc >= TMO && cyc <= TMO + 10, "R8 timeout latency", cyc, TMO);
    @(negedge clk);
    chk(!busy, "R10 idle after abort", int'(busy), 0);
    sl_scl = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clr_mon();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_std();
    t_stretch(1500, 1'b1, 1);
    t_hold_err();
    t_alt(1'b0);
    t_alt(1'b1);
    t_busy_tmo();
    t_stretch(200, 1'b0, 9);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule